// File: doc/BRIEF.md
# Two-by-Two Clock Crosspoint with Clean Bank Enables

This block steers two free-running input clocks onto two output banks. Each bank drives a parameterised number of outputs, three by default, and every output is a true and complement pair. A two-bit mode input selects the routing. Two modes copy one source clock to every output. One mode feeds each bank from its own source. The last mode crosses the sources over.

Each bank has an active-low enable that may change at any moment, with no timing relation to either clock. The block carries that enable through a chain of flops clocked on the falling edge of the clock the bank currently receives. A small gate state machine on the same edge then decides whether the bank passes the clock. Because the gate can only change while the routed clock is low, a bank starts on a full high phase and stops after a full high phase. It never shows a shortened pulse.

The gate state machine has two states. `GATE_OFF` holds the true outputs low and the complements high. `GATE_ON` passes the routed clock. The transition `turn_on` (`GATE_OFF` to `GATE_ON`) is taken when the synchronised enable reads active. The transition `turn_off` (`GATE_ON` to `GATE_OFF`) is taken when it reads inactive. Every other edge stays in the current state. Changing the mode while a bank is enabled is not guaranteed to be clean.

Top module: `xpt_clock_router`

## Requirements
- R1: `route_sel` selects the bank sources as follows. 2'b00 feeds `clk0` to both banks. 2'b01 feeds `clk1` to both banks. 2'b10 feeds `clk0` to bank A and `clk1` to bank B. 2'b11 feeds `clk1` to bank A and `clk0` to bank B.
- R2: All true outputs of a bank carry the same value at all times. While the bank is enabled and settled, they follow the bank's routed clock.
- R3: Every complement output is the inverse of its true output at all times, including during reset and while disabled.
- R4: After a bank's enable input goes high (disabled), the bank passes a further SYNC_FLOPS or SYNC_FLOPS+1 complete high pulses of its routed clock. With the default of 2, that is 2 when the change falls in the clock's high phase and 3 when it falls in the low phase. After that the true outputs stay low and the complements stay high.
- R5: After a bank's enable input goes low (enabled), SYNC_FLOPS or SYNC_FLOPS+1 rising edges of the routed clock are suppressed. With the default of 2, that is 2 for a change in the high phase and 3 for a change in the low phase. The following high phase appears in full and the clock then passes continuously.
- R6: Whatever the timing of the enable changes, every high pulse on a true output lasts exactly one high phase of the routed clock.
- R7: An active-high `rst` asynchronously forces both banks to the disabled output state at once. After `rst` is released with the enable held low, a bank starts like a fresh enable: SYNC_FLOPS rising edges are suppressed when the release falls in the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | First source clock |
| clk1 | input | 1 | Second source clock |
| rst | input | 1 | Asynchronous active-high reset |
| route_sel | input | 2 | Routing mode (see R1) |
| oe_a_n | input | 1 | Bank A enable, active low, asynchronous |
| oe_b_n | input | 1 | Bank B enable, active low, asynchronous |
| qa_p | output | OUTS_PER_BANK | Bank A true outputs |
| qa_n | output | OUTS_PER_BANK | Bank A complement outputs |
| qb_p | output | OUTS_PER_BANK | Bank B true outputs |
| qb_n | output | OUTS_PER_BANK | Bank B complement outputs |

## Verification
A wrong gate state shows at the ports within one routed clock period: in the next high phase a disabled bank emits a pulse, or an enabled bank stays silent. A synchroniser chain that is too short or too long shifts the count of passed or suppressed edges after an enable change by one. The phase-aligned latency tests therefore catch it on the first toggle. A gate that changes outside the low phase shows up as a high pulse narrower than the routed clock's high phase. The pulse-width monitor then flags it at that pulse's falling edge.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    localparam int NUM_BANKS = 2;
    localparam int NUM_SRCS  = 2;

    typedef enum logic [1:0] {
        ROUTE_FAN0     = 2'b00,
        ROUTE_FAN1     = 2'b01,
        ROUTE_STRAIGHT = 2'b10,
        ROUTE_CROSS    = 2'b11
    } route_mode_e;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

endpackage

// File: rtl/xpt_route_dec.sv
module xpt_route_dec
    import xpt_pkg::*;
(
    input  logic [1:0]           route_sel,
    output logic [NUM_BANKS-1:0] bank_src
);

    route_mode_e mode;
    assign mode = route_mode_e'(route_sel);

    // bank_src[b] = 0 selects clk0, 1 selects clk1; bit 0 is bank A
    always_comb begin
        unique case (mode)
            ROUTE_FAN0:     bank_src = 2'b00;
            ROUTE_FAN1:     bank_src = 2'b11;
            ROUTE_STRAIGHT: bank_src = 2'b10;
            ROUTE_CROSS:    bank_src = 2'b01;
            default:        bank_src = 2'b00;
        endcase
    end

endmodule

// File: rtl/xpt_bank_gate.sv
module xpt_bank_gate
    import xpt_pkg::*;
#(
    parameter int OUTS_PER_BANK = 3,
    parameter int SYNC_FLOPS    = 2
) (
    input  logic                     bank_clk,
    input  logic                     rst,
    input  logic                     oe_n,
    output logic [OUTS_PER_BANK-1:0] out_p,
    output logic [OUTS_PER_BANK-1:0] out_n,
    output logic                     gate_on
);

    localparam int SYNC_MSB = SYNC_FLOPS - 1;

    logic [SYNC_MSB:0] sync_q;
    gate_state_e       state_q;
    gate_state_e       state_d;
    logic              pass;

    // enable synchroniser, falling edge of the routed clock, resets disabled
    always_ff @(negedge bank_clk or posedge rst) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_MSB-1:0], oe_n};
        end
    end

    // state register: updates only on the falling edge, so only in the low phase
    always_ff @(negedge bank_clk or posedge rst) begin
        if (rst) begin
            state_q <= GATE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: turn_on / turn_off
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (!sync_q[SYNC_MSB]) state_d = GATE_ON;
            GATE_ON:  if (sync_q[SYNC_MSB])  state_d = GATE_OFF;
            default:  state_d = GATE_OFF;
        endcase
    end

    // outputs
    always_comb begin
        pass    = (state_q == GATE_ON);
        gate_on = pass;
        out_p   = {OUTS_PER_BANK{bank_clk & pass}};
        out_n   = ~out_p;
    end

endmodule

// File: rtl/xpt_clock_router.sv
module xpt_clock_router
    import xpt_pkg::*;
#(
    parameter int OUTS_PER_BANK = 3,
    parameter int SYNC_FLOPS    = 2
) (
    input  logic                     clk0,
    input  logic                     clk1,
    input  logic                     rst,
    input  logic [1:0]               route_sel,
    input  logic                     oe_a_n,
    input  logic                     oe_b_n,
    output logic [OUTS_PER_BANK-1:0] qa_p,
    output logic [OUTS_PER_BANK-1:0] qa_n,
    output logic [OUTS_PER_BANK-1:0] qb_p,
    output logic [OUTS_PER_BANK-1:0] qb_n
);

    logic [NUM_SRCS-1:0]                      clk_src;
    logic [NUM_BANKS-1:0]                     bank_src;
    logic [NUM_BANKS-1:0]                     bank_clk;
    logic [NUM_BANKS-1:0]                     bank_oe_n;
    logic [NUM_BANKS-1:0]                     gate_on;
    logic [NUM_BANKS-1:0][OUTS_PER_BANK-1:0]  bank_p;
    logic [NUM_BANKS-1:0][OUTS_PER_BANK-1:0]  bank_n;

    assign clk_src   = {clk1, clk0};
    assign bank_oe_n = {oe_b_n, oe_a_n};

    xpt_route_dec u_dec (
        .route_sel (route_sel),
        .bank_src  (bank_src)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_clk[b] = clk_src[bank_src[b]];

        xpt_bank_gate #(
            .OUTS_PER_BANK (OUTS_PER_BANK),
            .SYNC_FLOPS    (SYNC_FLOPS)
        ) u_gate (
            .bank_clk (bank_clk[b]),
            .rst      (rst),
            .oe_n     (bank_oe_n[b]),
            .out_p    (bank_p[b]),
            .out_n    (bank_n[b]),
            .gate_on  (gate_on[b])
        );
    end

    assign qa_p = bank_p[0];
    assign qa_n = bank_n[0];
    assign qb_p = bank_p[1];
    assign qb_n = bank_n[1];

endmodule

// File: rtl/xpt_router_chk.sv
module xpt_router_chk #(
    parameter int OUTS_PER_BANK = 3,
    parameter int SYNC_FLOPS    = 2
) (
    input logic                     rst,
    input logic                     oe_a_n,
    input logic                     oe_b_n,
    input logic [OUTS_PER_BANK-1:0] qa_p,
    input logic [OUTS_PER_BANK-1:0] qa_n,
    input logic [OUTS_PER_BANK-1:0] qb_p,
    input logic [OUTS_PER_BANK-1:0] qb_n,
    input logic [1:0]               bank_clk,
    input logic [1:0]               gate_on
);

    localparam int CNT_W = $clog2(SYNC_FLOPS + 2) + 1;
    localparam logic [CNT_W-1:0] SETTLE = CNT_W'(SYNC_FLOPS + 1);

    logic [1:0]                     oe_n;
    logic [1:0][OUTS_PER_BANK-1:0]  q_p;
    logic [1:0][OUTS_PER_BANK-1:0]  q_n;

    assign oe_n = {oe_b_n, oe_a_n};
    assign q_p  = {qb_p, qa_p};
    assign q_n  = {qb_n, qa_n};

    for (genvar b = 0; b < 2; b++) begin : g_chk
        logic             last_oe;
        logic [CNT_W-1:0] same_cnt;

        // counts consecutive falling edges that saw the same enable level
        always_ff @(negedge bank_clk[b] or posedge rst) begin
            if (rst) begin
                last_oe  <= 1'b1;
                same_cnt <= '0;
            end else if (oe_n[b] != last_oe) begin
                last_oe  <= oe_n[b];
                same_cnt <= CNT_W'(1);
            end else if (same_cnt != '1) begin
                same_cnt <= same_cnt + CNT_W'(1);
            end
        end

        a_r4_settles_off: assert property (@(negedge bank_clk[b]) disable iff (rst)
            (last_oe && same_cnt >= SETTLE) |-> !gate_on[b]);

        a_r5_settles_on: assert property (@(negedge bank_clk[b]) disable iff (rst)
            (!last_oe && same_cnt >= SETTLE) |-> gate_on[b]);

        a_r2_bank_uniform: assert property (@(negedge bank_clk[b]) disable iff (rst)
            ($countones(q_p[b]) == 0) || ($countones(q_p[b]) == OUTS_PER_BANK));

        a_r3_complement: assert property (@(negedge bank_clk[b]) disable iff (rst)
            q_n[b] == ~q_p[b]);
    end

endmodule

bind xpt_clock_router xpt_router_chk #(
    .OUTS_PER_BANK (OUTS_PER_BANK),
    .SYNC_FLOPS    (SYNC_FLOPS)
) u_chk (
    .rst      (rst),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .qa_p     (qa_p),
    .qa_n     (qa_n),
    .qb_p     (qb_p),
    .qb_n     (qb_n),
    .bank_clk (bank_clk),
    .gate_on  (gate_on)
);

// File: tb/test_xpt_clock_router.sv
`timescale 1ns/10ps
module test_xpt_clock_router;

    localparam int  OUTS       = 3;
    localparam int  SYNC       = 2;
    localparam real CLK_PERIOD = 10.0;
    localparam real CLK0_HALF  = CLK_PERIOD / 2.0;
    localparam real CLK1_HALF  = 7.0;

    typedef struct packed {
        logic [1:0] sel;
        logic       oea_n;
        logic       oeb_n;
        logic       srca;
        logic       srcb;
    } vec_t;

    // R1 encoding: srca/srcb 0 = clk0, 1 = clk1
    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1},
        '{2'b11, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'b11, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'b01, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    logic            clk0, clk1, rst;
    logic [1:0]      route_sel;
    logic            oe_a_n, oe_b_n;
    logic [OUTS-1:0] qa_p, qa_n, qb_p, qb_n;

    int  tests, fails;
    int  runts, pulses;
    bit  mon_en, done;
    real exp_hi_a, exp_hi_b;
    real rise_a, rise_b;

    xpt_clock_router #(.OUTS_PER_BANK(OUTS), .SYNC_FLOPS(SYNC)) i_xpt_clock_router (
        .clk0 (clk0), .clk1 (clk1), .rst (rst), .route_sel (route_sel),
        .oe_a_n (oe_a_n), .oe_b_n (oe_b_n),
        .qa_p (qa_p), .qa_n (qa_n), .qb_p (qb_p), .qb_n (qb_n)
    );

    initial begin
        clk0 = 1'b0;
        forever #(CLK0_HALF) clk0 = ~clk0;
    end

    initial begin
        clk1 = 1'b0;
        #0.25;
        forever #(CLK1_HALF) clk1 = ~clk1;
    end

    // R6 pulse-width monitors
    always @(posedge qa_p[0]) rise_a = $realtime;
    always @(negedge qa_p[0]) if (mon_en) begin
        pulses++;
        if (($realtime - rise_a - exp_hi_a) > 0.01 || (exp_hi_a - ($realtime - rise_a)) > 0.01) runts++;
    end
    always @(posedge qb_p[0]) rise_b = $realtime;
    always @(negedge qb_p[0]) if (mon_en) begin
        pulses++;
        if (($realtime - rise_b - exp_hi_b) > 0.01 || (exp_hi_b - ($realtime - rise_b)) > 0.01) runts++;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
        end
    endtask

    task automatic set_sel(input logic [1:0] s);
        route_sel = s;
        exp_hi_a  = s[0] ? CLK1_HALF : CLK0_HALF;
        exp_hi_b  = (s[1] ? ~s[0] : s[0]) ? CLK1_HALF : CLK0_HALF;
    endtask

    // edges of clk0 that pass after a disable, counted from now
    task automatic count_passed(input bit bank_b, output int n);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk0); #1;
            if ((bank_b ? qb_p[0] : qa_p[0]) === 1'b1) n++;
            else break;
        end
    endtask

    // edges of clk0 suppressed after an enable, counted from now
    task automatic count_blocked(input bit bank_b, output int n);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk0); #1;
            if ((bank_b ? qb_p[0] : qa_p[0]) === 1'b1) break;
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int n, ea, eb, err_a, err_b, err_c;
        tests = 0; fails = 0; runts = 0; pulses = 0;
        mon_en = 1'b0; done = 1'b0;
        rst = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
        set_sel(2'b00);

        // R7, R3: reset state with enables asserted
        #10.5;
        check(qa_p == '0 && qb_p == '0, "R7", "outputs low in reset", int'({qb_p, qa_p}), 0);
        check(qa_n == '1 && qb_n == '1, "R3", "complements high in reset", int'({qb_n, qa_n}), 63);
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        #10;
        rst = 1'b0;
        #20;
        mon_en = 1'b1;

        // R1 R2 R3: vector table
        for (int i = 0; i < 8; i++) begin
            oe_a_n = 1'b1; oe_b_n = 1'b1;
            #60;
            set_sel(VECS[i].sel);
            #10;
            oe_a_n = VECS[i].oea_n; oe_b_n = VECS[i].oeb_n;
            #80;
            @(negedge clk0); #2.5;
            err_a = 0; err_b = 0; err_c = 0;
            for (int s = 0; s < 60; s++) begin
                ea = VECS[i].oea_n ? 0 : int'(VECS[i].srca ? clk1 : clk0);
                eb = VECS[i].oeb_n ? 0 : int'(VECS[i].srcb ? clk1 : clk0);
                if (qa_p !== {OUTS{ea[0]}}) err_a++;
                if (qb_p !== {OUTS{eb[0]}}) err_b++;
                if (qa_n !== ~qa_p || qb_n !== ~qb_p) err_c++;
                #1;
            end
            check(err_a == 0, "R1 R2", $sformatf("bank A vector %0d mismatches", i), err_a, 0);
            check(err_b == 0, "R1 R2", $sformatf("bank B vector %0d mismatches", i), err_b, 0);
            check(err_c == 0, "R3", $sformatf("complement vector %0d mismatches", i), err_c, 0);
        end

        // R4 R5: latency windows on bank A fed by clk0
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        #60;
        set_sel(2'b00);
        oe_a_n = 1'b0;
        #100;
        @(posedge clk0); #2; oe_a_n = 1'b1;
        count_passed(1'b0, n);
        check(n == SYNC, "R4", "bank A pulses after disable in high phase", n, SYNC);
        #100;
        @(posedge clk0); #7; oe_a_n = 1'b0;
        count_blocked(1'b0, n);
        check(n == SYNC + 1, "R5", "bank A edges blocked after enable in low phase", n, SYNC + 1);
        #100;
        @(posedge clk0); #7; oe_a_n = 1'b1;
        count_passed(1'b0, n);
        check(n == SYNC + 1, "R4", "bank A pulses after disable in low phase", n, SYNC + 1);
        #100;
        @(posedge clk0); #2; oe_a_n = 1'b0;
        count_blocked(1'b0, n);
        check(n == SYNC, "R5", "bank A edges blocked after enable in high phase", n, SYNC);

        // R4 R5: bank B fed by clk0 in the crossed mode
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        #60;
        set_sel(2'b11);
        #100;
        @(posedge clk0); #2; oe_b_n = 1'b0;
        count_blocked(1'b1, n);
        check(n == SYNC, "R5", "bank B edges blocked after enable in high phase", n, SYNC);
        #100;
        @(posedge clk0); #7; oe_b_n = 1'b1;
        count_passed(1'b1, n);
        check(n == SYNC + 1, "R4", "bank B pulses after disable in low phase", n, SYNC + 1);
        #60;
        check(qb_p == '0 && qb_n == '1, "R4", "bank B held off", int'(qb_p), 0);

        // R6: enables toggled at arbitrary times, clocks unrelated
        @(negedge clk0); #2.5;
        n = pulses;
        for (int k = 0; k < 250; k++) begin
            #($urandom_range(1, 30));
            oe_a_n = 1'($urandom_range(0, 1));
            oe_b_n = 1'($urandom_range(0, 1));
        end
        oe_a_n = 1'b0; oe_b_n = 1'b0;
        #100;
        check(runts == 0, "R6", "short pulses under random enables", runts, 0);
        check(pulses > n, "R6", "pulses seen under random enables", pulses - n, 1);

        // R7: reset mid-run, then restart
        set_sel(2'b11);
        mon_en = 1'b0;
        @(negedge clk1); #3.25;
        rst = 1'b1;
        #1;
        check(qa_p == '0 && qb_p == '0, "R7", "outputs drop at once on reset", int'({qb_p, qa_p}), 0);
        #30;
        check(qa_n == '1 && qb_n == '1 && qa_p == '0, "R7", "outputs held during reset", int'({qb_n, qa_n}), 63);
        set_sel(2'b00);
        @(posedge clk0); #2; rst = 1'b0;
        count_blocked(1'b0, n);
        check(n == SYNC, "R7", "edges blocked after reset release", n, SYNC);
        #2;
        mon_en = 1'b1;
        #200;
        check(runts == 0, "R6", "short pulses after restart", runts, 0);

        summary();
        $finish;
    end

endmodule